// File: doc/BRIEF.md
# LCD Controller Register Block

This block is the software-visible register set of a simple colour LCD controller. It sits on a 32-bit bus with word addressing and a 4 KB window. The block holds four display timing words, the base addresses of the upper and lower panels, and a control word. It also holds an interrupt section with raw status, mask, masked status and a write-one-to-clear port, and it returns eight read-only identification bytes near the top of the window.

The timing words are decoded into the active column and row counts that the pixel pipeline uses. The control word drives an enable output and the pixel-format fields. An internal divider produces a frame tick while the controller is enabled. Each tick raises two status bits, and the level interrupt follows the masked status.

Two straps set the variant. One strap exchanges the word offsets of the mask and control registers. The other strap selects the alternate identification byte set. Read data is combinational from the word address.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, every storage register reads zero, `irq` and `lcd_enabled` are low, and `active_cols` and `active_rows` are zero.
- R2: A write to word 0 stores the whole word. From the next cycle, `active_cols` equals (wdata[7:2] + 1) * 16, which gives the range 16 to 1024.
- R3: A write to word 1 stores the whole word. From the next cycle, `active_rows` equals wdata[9:0] + 1, which gives the range 1 to 1024.
- R4: `lcd_enabled` is high only when control bit 0 and control bit 11 are both set. The control word also drives these outputs: bits [3:1] give `pix_depth`, bit 8 gives `swap_rb`, bit 9 gives `be_bytes` and bit 10 gives `be_pixels`.
- R5: Words 2 and 3 read back as written. Words 4 and 5 hold the upper and lower panel bases. Words 11 and 12 return the same values as words 4 and 5.
- R6: With `swap_strap` low, word 6 is the mask and word 7 is control. With `swap_strap` high, the two roles are exchanged for both reads and writes.
- R7: While enabled, status bits 2 and 3 are set every TICK_CYCLES cycles. The first setting is seen TICK_CYCLES cycles after the enabling write. The other status bits always read zero. Raw status is read at word 8.
- R8: While disabled, no frame tick occurs, and the raw status holds its value.
- R9: `irq` is high exactly when (raw status AND mask) is nonzero. Word 9 reads the masked status.
- R10: A write to word 10 clears the status bits that are set in wdata. If a frame tick falls in the same cycle, the tick's bits end up set.
- R11: Words 0x3F8 to 0x3FF return one identification byte each: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. With `id_alt` high, the first three bytes are 0x11, 0x11 and 0x24.
- R12: Reads of words 10, 13 to 0x3F7 return zero. Writes to words 8, 9, 11, 12, the identification words and unused words change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| swap_strap | input | 1 | Exchanges the mask and control word offsets |
| id_alt | input | 1 | Selects the alternate identification bytes |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 10 | Word address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| active_cols | output | 11 | Decoded active columns |
| active_rows | output | 11 | Decoded active rows |
| lcd_enabled | output | 1 | Enable and power both set |
| pix_depth | output | 3 | Pixel depth code |
| swap_rb | output | 1 | Red/blue order select |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| irq | output | 1 | Level interrupt |

## Verification
The bench puts a clear write in the same cycle as a frame tick. A design that gives the clear priority would lose the tick and read zero status. It checks the first tick at exactly TICK_CYCLES cycles, so a counter that is off by one shows up as early or late status. It also checks that status stays frozen after disabling, which catches a divider that keeps running. The bench flips the offset strap with live registers, so a design that swaps only reads or only writes returns the wrong word. It also writes all ones to the read-only and unused words and to the decoder extremes: timing fields of all zeros and all ones give 16 and 1024 columns and 1 and 1024 rows.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int DW     = 32;
  localparam int ADDR_W = 10;
  localparam int DIM_W  = 11;

  localparam logic [ADDR_W-1:0] OFS_UPBASE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_LPBASE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFS_LOW6   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_HIGH7  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] OFS_RAW    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_MSK    = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] OFS_CLR    = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] OFS_UPCUR  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] OFS_LPCUR  = ADDR_W'(12);
  localparam logic [ADDR_W-4:0] ID_PAGE    = '1;

  localparam logic [DW-1:0] TICK_BITS = 32'h0000_000C;

  // columns = (field + 1) * 16
  function automatic logic [DIM_W-1:0] cols_of(input logic [5:0] f);
    return {7'({1'b0, f}) + 7'd1, 4'b0000};
  endfunction

  function automatic logic [DIM_W-1:0] rows_of(input logic [9:0] f);
    return DIM_W'(f) + DIM_W'(1);
  endfunction

  function automatic logic ctrl_on(input logic [DW-1:0] c);
    return c[0] & c[11];
  endfunction

  function automatic logic [7:0] id_byte(input logic alt, input logic [2:0] i);
    case (i)
      3'd0:    return alt ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return alt ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcdc_frame_tick.sv
module lcdc_frame_tick #(
  parameter int TICK_CYCLES = 833_333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(TICK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl
  import lcdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  output logic [DW-1:0] raw_status,
  output logic [DW-1:0] mask,
  output logic          irq
);
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] set_vec;

  assign clr_vec = clr_we ? wdata : '0;
  assign set_vec = tick ? TICK_BITS : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_status <= '0;
      mask       <= '0;
    end else begin
      raw_status <= (raw_status & ~clr_vec) | set_vec;
      if (mask_we) mask <= wdata;
    end
  end

  assign irq = |(raw_status & mask);
endmodule

// File: rtl/lcdc_rd_mux.sv
module lcdc_rd_mux
  import lcdc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              swap,
  input  logic              id_alt,
  input  logic [DW-1:0]     t0,
  input  logic [DW-1:0]     t1,
  input  logic [DW-1:0]     t2,
  input  logic [DW-1:0]     t3,
  input  logic [DW-1:0]     upbase,
  input  logic [DW-1:0]     lpbase,
  input  logic [DW-1:0]     ctrl,
  input  logic [DW-1:0]     mask,
  input  logic [DW-1:0]     raw,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1:3] == ID_PAGE) begin
      rdata = DW'(id_byte(id_alt, addr[2:0]));
    end else begin
      case (addr)
        ADDR_W'(0): rdata = t0;
        ADDR_W'(1): rdata = t1;
        ADDR_W'(2): rdata = t2;
        ADDR_W'(3): rdata = t3;
        OFS_UPBASE, OFS_UPCUR: rdata = upbase;
        OFS_LPBASE, OFS_LPCUR: rdata = lpbase;
        OFS_LOW6:   rdata = swap ? ctrl : mask;
        OFS_HIGH7:  rdata = swap ? mask : ctrl;
        OFS_RAW:    rdata = raw;
        OFS_MSK:    rdata = raw & mask;
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int TICK_CYCLES = 833_333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_strap,
  input  logic              id_alt,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DIM_W-1:0]  active_cols,
  output logic [DIM_W-1:0]  active_rows,
  output logic              lcd_enabled,
  output logic [2:0]        pix_depth,
  output logic              swap_rb,
  output logic              be_bytes,
  output logic              be_pixels,
  output logic              irq
);
  logic [DW-1:0] timing_q [4];
  logic [DW-1:0] upbase_q, lpbase_q, ctrl_q;
  logic [DW-1:0] mask_w, raw_status;

  // named write events
  logic wr, wr_t0, wr_t1, wr_ctrl, wr_mask, wr_clr, frame_tick;
  logic [ADDR_W-1:0] ctrl_ofs, mask_ofs;

  assign wr       = bus_en & bus_we;
  assign ctrl_ofs = swap_strap ? OFS_LOW6 : OFS_HIGH7;
  assign mask_ofs = swap_strap ? OFS_HIGH7 : OFS_LOW6;
  assign wr_t0    = wr && (bus_addr == ADDR_W'(0));
  assign wr_t1    = wr && (bus_addr == ADDR_W'(1));
  assign wr_ctrl  = wr && (bus_addr == ctrl_ofs);
  assign wr_mask  = wr && (bus_addr == mask_ofs);
  assign wr_clr   = wr && (bus_addr == OFS_CLR);

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_timing
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  timing_q[gi] <= '0;
        else if (wr && (bus_addr == ADDR_W'(gi)))    timing_q[gi] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upbase_q    <= '0;
      lpbase_q    <= '0;
      ctrl_q      <= '0;
      active_cols <= '0;
      active_rows <= '0;
    end else begin
      if (wr && (bus_addr == OFS_UPBASE)) upbase_q <= bus_wdata;
      if (wr && (bus_addr == OFS_LPBASE)) lpbase_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_t0)   active_cols <= cols_of(bus_wdata[7:2]);
      if (wr_t1)   active_rows <= rows_of(bus_wdata[9:0]);
    end
  end

  assign lcd_enabled = ctrl_on(ctrl_q);
  assign pix_depth   = ctrl_q[3:1];
  assign swap_rb     = ctrl_q[8];
  assign be_bytes    = ctrl_q[9];
  assign be_pixels   = ctrl_q[10];

  lcdc_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (lcd_enabled),
    .tick  (frame_tick)
  );

  lcdc_irq_ctrl irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (wr_mask),
    .clr_we     (wr_clr),
    .wdata      (bus_wdata),
    .tick       (frame_tick),
    .raw_status (raw_status),
    .mask       (mask_w),
    .irq        (irq)
  );

  lcdc_rd_mux rd_i (
    .addr   (bus_addr),
    .swap   (swap_strap),
    .id_alt (id_alt),
    .t0     (timing_q[0]),
    .t1     (timing_q[1]),
    .t2     (timing_q[2]),
    .t3     (timing_q[3]),
    .upbase (upbase_q),
    .lpbase (lpbase_q),
    .ctrl   (ctrl_q),
    .mask   (mask_w),
    .raw    (raw_status),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk
  import lcdc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_t0,
  input logic             wr_t1,
  input logic             wr_clr,
  input logic [DW-1:0]    bus_wdata,
  input logic             frame_tick,
  input logic             lcd_enabled,
  input logic [DW-1:0]    raw_status,
  input logic             irq,
  input logic [DIM_W-1:0] active_cols,
  input logic [DIM_W-1:0] active_rows
);
  // R2
  cols_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t0 |=> (active_cols[3:0] == 4'd0) && (active_cols != '0));

  // R3
  rows_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_t1 |=> (active_rows != '0));

  // R7
  tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (raw_status[3:2] == 2'b11));

  // R7
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[DW-1:4] == '0) && (raw_status[1:0] == 2'b00));

  // R8
  frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_enabled && !wr_clr) |=> $stable(raw_status));

  // R10
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && (bus_wdata == '1) && !frame_tick) |=> !irq);
endmodule

bind lcdc_regs lcdc_regs_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_t0       (wr_t0),
  .wr_t1       (wr_t1),
  .wr_clr      (wr_clr),
  .bus_wdata   (bus_wdata),
  .frame_tick  (frame_tick),
  .lcd_enabled (lcd_enabled),
  .raw_status  (raw_status),
  .irq         (irq),
  .active_cols (active_cols),
  .active_rows (active_rows)
);

// File: tb/lcdc_regs_tb_top.sv
module lcdc_regs_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        swap_strap = 1'b0;
  logic        id_alt = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] active_cols, active_rows;
  logic        lcd_enabled, swap_rb, be_bytes, be_pixels, irq;
  logic [2:0]  pix_depth;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcdc_regs #(.TICK_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .swap_strap(swap_strap), .id_alt(id_alt),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active_cols(active_cols), .active_rows(active_rows),
    .lcd_enabled(lcd_enabled), .pix_depth(pix_depth), .swap_rb(swap_rb),
    .be_bytes(be_bytes), .be_pixels(be_pixels), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 13; a++) rd_chk("R1 reg", 10'(a), 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 en", 32'(lcd_enabled), 0);
    chk("R1 cols", 32'(active_cols), 0);
    chk("R1 rows", 32'(active_rows), 0);
  endtask

  task automatic t_geometry;
    wr(10'd0, 32'hFFFF_FFFF);
    chk("R2 cols max", 32'(active_cols), 1024);
    rd_chk("R2 readback", 10'd0, 32'hFFFF_FFFF);
    wr(10'd0, 32'h0000_0013);
    chk("R2 cols 80", 32'(active_cols), 80);
    wr(10'd0, 32'h0000_0003);
    chk("R2 cols min", 32'(active_cols), 16);
    wr(10'd1, 32'h0000_03FF);
    chk("R3 rows max", 32'(active_rows), 1024);
    wr(10'd1, 32'h0000_01DF);
    chk("R3 rows 480", 32'(active_rows), 480);
    wr(10'd1, 32'hFFFF_FC00);
    chk("R3 rows min", 32'(active_rows), 1);
    rd_chk("R3 readback", 10'd1, 32'hFFFF_FC00);
  endtask

  task automatic t_control;
    wr(10'd7, 32'h0000_0001);
    chk("R4 enable only", 32'(lcd_enabled), 0);
    wr(10'd7, 32'h0000_0800);
    chk("R4 power only", 32'(lcd_enabled), 0);
    wr(10'd7, 32'h0000_070A);
    chk("R4 depth", 32'(pix_depth), 5);
    chk("R4 fields", {29'b0, swap_rb, be_bytes, be_pixels}, 32'h7);
    chk("R4 off", 32'(lcd_enabled), 0);
    wr(10'd7, 32'h0000_0801);
    chk("R4 on", 32'(lcd_enabled), 1);
    chk("R4 depth zero", 32'(pix_depth), 0);
    wr(10'd7, 32'h0);
    wr(10'd10, 32'hFFFF_FFFF);
  endtask

  task automatic t_bases;
    wr(10'd2, 32'hA5A5_0001);
    wr(10'd3, 32'h5A5A_0002);
    wr(10'd4, 32'h1234_5678);
    wr(10'd5, 32'h8765_4320);
    rd_chk("R5 t2", 10'd2, 32'hA5A5_0001);
    rd_chk("R5 t3", 10'd3, 32'h5A5A_0002);
    rd_chk("R5 up", 10'd4, 32'h1234_5678);
    rd_chk("R5 lp", 10'd5, 32'h8765_4320);
    rd_chk("R5 upcur", 10'd11, 32'h1234_5678);
    rd_chk("R5 lpcur", 10'd12, 32'h8765_4320);
  endtask

  task automatic t_tick_irq;
    wr(10'd7, 32'h0000_0801);
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    rd_chk("R7 not yet", 10'd8, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rd_chk("R7 first tick", 10'd8, 32'hC);
    wr(10'd7, 32'h0);
    repeat (3 * N) @(posedge clk);
    @(negedge clk);
    rd_chk("R8 frozen", 10'd8, 32'hC);
    chk("R9 masked off", 32'(irq), 0);
    rd_chk("R9 mis zero", 10'd9, 32'h0);
    wr(10'd6, 32'h0000_0004);
    chk("R9 irq on", 32'(irq), 1);
    rd_chk("R9 mis", 10'd9, 32'h4);
    wr(10'd10, 32'h0000_0004);
    rd_chk("R10 partial", 10'd8, 32'h8);
    chk("R10 irq off", 32'(irq), 0);
    wr(10'd6, 32'hFFFF_FFFF);
    chk("R9 irq bit3", 32'(irq), 1);
    rd_chk("R6 mask rb", 10'd6, 32'hFFFF_FFFF);
    wr(10'd10, 32'hFFFF_FFFF);
    chk("R10 full clear", 32'(irq), 0);
    // clear in the same cycle as the first tick
    wr(10'd7, 32'h0000_0801);
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    wr(10'd10, 32'hFFFF_FFFF);
    rd_chk("R10 tick wins", 10'd8, 32'hC);
    wr(10'd7, 32'h0);
    wr(10'd10, 32'hFFFF_FFFF);
    wr(10'd6, 32'h0);
  endtask

  task automatic t_swap;
    swap_strap = 1'b1;
    wr(10'd6, 32'h0000_0801);
    chk("R6 ctrl at 6", 32'(lcd_enabled), 1);
    wr(10'd7, 32'h0000_005A);
    rd_chk("R6 swapped 6", 10'd6, 32'h0000_0801);
    rd_chk("R6 swapped 7", 10'd7, 32'h0000_005A);
    swap_strap = 1'b0;
    #1;
    rd_chk("R6 plain 6", 10'd6, 32'h0000_005A);
    rd_chk("R6 plain 7", 10'd7, 32'h0000_0801);
    wr(10'd7, 32'h0);
    chk("R6 off", 32'(lcd_enabled), 0);
    wr(10'd6, 32'h0);
    wr(10'd10, 32'hFFFF_FFFF);
  endtask

  task automatic t_id;
    logic [7:0] exp_b [8];
    exp_b = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) rd_chk("R11 id", 10'(10'h3F8 + i), 32'(exp_b[i]));
    id_alt = 1'b1;
    #1;
    rd_chk("R11 alt0", 10'h3F8, 32'h11);
    rd_chk("R11 alt1", 10'h3F9, 32'h11);
    rd_chk("R11 alt2", 10'h3FA, 32'h24);
    rd_chk("R11 alt7", 10'h3FF, 32'hB1);
    id_alt = 1'b0;
  endtask

  task automatic t_readonly;
    wr(10'd8, 32'hFFFF_FFFF);
    wr(10'd9, 32'hFFFF_FFFF);
    wr(10'd11, 32'hFFFF_FFFF);
    wr(10'd12, 32'hFFFF_FFFF);
    wr(10'h3F8, 32'hFFFF_FFFF);
    wr(10'd13, 32'hFFFF_FFFF);
    wr(10'h200, 32'hFFFF_FFFF);
    rd_chk("R12 raw", 10'd8, 32'h0);
    rd_chk("R12 upcur", 10'd11, 32'h1234_5678);
    rd_chk("R12 lpcur", 10'd12, 32'h8765_4320);
    rd_chk("R12 id", 10'h3F8, 32'h10);
    rd_chk("R12 word13", 10'd13, 32'h0);
    rd_chk("R12 word200", 10'h200, 32'h0);
    rd_chk("R12 word3F7", 10'h3F7, 32'h0);
    rd_chk("R12 clr word", 10'd10, 32'h0);
    rd_chk("R12 t0 kept", 10'd0, 32'h0000_0003);
    chk("R12 en", 32'(lcd_enabled), 0);
    chk("R12 irq", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_geometry();
    t_control();
    t_bases();
    t_tick_irq();
    t_swap();
    t_id();
    t_readonly();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule